// File: doc/BRIEF.md
# Dual-Channel Converter Command Interface

This block is the digital front end of a two-channel 13-bit converter. A host writes 16-bit command frames over a three-wire serial link with chip-select, clock and data in. The link uses clock polarity 0 and phase 0. The block keeps two registers for each channel:

- a staging register that receives new codes;
- a live register that feeds the converter.

Because of this double buffering, the host can stage a new code without disturbing the output. It can then move both staged codes to the outputs in one step, or stage and move in a single frame. Mode frames set three things: a general-purpose output level, a shutdown state with a choice of how the channels come back, and the serial clock edge on which the echo output shifts.

The serial pins are sampled with a system clock that runs at least eight times faster than the serial clock, through synchronizers. A frame takes effect only on the rising edge of chip-select, and only when exactly 16 bits were clocked in. Frames of any other length leave every register as it was.

Top module: `dual_dac_cmd_if`

## Requirements
- R1: After reset both channel outputs are 0, the general-purpose output is low, shutdown is off, the echo output is 0, and the echo shifts on the falling serial clock edge.
- R2: A frame is 16 bits, most significant first, and each bit is taken on a rising serial clock edge while chip-select is low. The bits are: bit 15 the channel select (0 = channel A, 1 = channel B), bits 14:13 the command code, bits 12:0 the data.
- R3: Command code 00 writes the data into the selected channel's staging register and leaves both channel outputs unchanged.
- R4: Command code 10 copies both staging registers into the live registers, whatever the data bits hold.
- R5: Command code 01 writes the data into the selected staging register and then copies both staging registers into the live registers.
- R6: Nothing a frame commands becomes visible until chip-select rises.
- R7: When chip-select rises after a bit count other than 16, the frame is dropped and no output or register changes.
- R8: While chip-select is high, serial clock and data activity have no effect, including on the echo output.
- R9: A frame split into two 8-bit bursts, with chip-select held low in the gap, acts exactly like a continuous frame.
- R10: Command code 11 with channel select 0 is a power frame. Data bit 12 sets shutdown and data bit 11 sets the general-purpose output. While shutdown is on, both channel outputs read 0.
- R11: Data bit 10 of a power frame that turns shutdown on picks the wake behaviour. With 1, turning shutdown off copies the staging registers into the live registers. With 0, the live registers keep their values.
- R12: Command code 11 with channel select 1 sets the echo edge from data bit 12 (1 = rising, 0 = falling). On every serial clock edge of the chosen kind while chip-select is low, the echo output presents the data bit that was clocked in 16 rising edges earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip-select |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial echo output |
| gpo_o | output | 1 | General-purpose logic output |
| shutdown_o | output | 1 | High while the converter is shut down |
| dac_a_o | output | 13 | Channel A code to the converter |
| dac_b_o | output | 13 | Channel B code to the converter |

## Verification
The bound checker watches four properties on every cycle:

- the channel outputs, general-purpose output and shutdown flag change only in the cycle after a committed frame;
- a chip-select rise with a bad bit count changes none of them;
- the shift register holds while chip-select is high;
- while shutdown is on, both codes read zero, and the echo output moves only after a detected serial clock edge.

Some behaviour can only be shown by the directed scenarios. These cover the meaning of each command code, the double-buffer ordering, the wake choice after shutdown, split-burst frames, and the exact bit the echo presents on each edge.

// File: rtl/dual_dac_pkg.sv
package dual_dac_pkg;
  localparam int FRAME_W = 16;
  localparam int DATA_W  = 13;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int N_CH    = 2;

  localparam int PWR_SHDN_BIT = DATA_W - 1;
  localparam int PWR_GPO_BIT  = DATA_W - 2;
  localparam int PWR_WAKE_BIT = DATA_W - 3;
  localparam int EDGE_SEL_BIT = DATA_W - 1;

  typedef enum logic [1:0] {
    CMD_STAGE     = 2'b00,
    CMD_STAGE_UPD = 2'b01,
    CMD_UPDATE    = 2'b10,
    CMD_MODE      = 2'b11
  } cmd_e;

  typedef struct packed {
    logic              chan;
    cmd_e              cmd;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/dual_dac_sampler.sv
module dual_dac_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic din,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_low,
  output logic cs_rise,
  output logic cs_fall,
  output logic din_s
);
  localparam logic [2:0] IDLE_VAL = 3'b010;

  logic [SYNC_STAGES-1:0][2:0] stg_q;
  logic [2:0] raw;
  logic [2:0] last_q;

  assign raw = {sclk, cs_n, din};

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= IDLE_VAL;
        else        stg_q[s] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= IDLE_VAL;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IDLE_VAL;
    else        last_q <= stg_q[SYNC_STAGES-1];
  end

  always_comb begin
    sclk_rise = stg_q[SYNC_STAGES-1][2] & ~last_q[2];
    sclk_fall = ~stg_q[SYNC_STAGES-1][2] & last_q[2];
    cs_low    = ~stg_q[SYNC_STAGES-1][1];
    cs_rise   = stg_q[SYNC_STAGES-1][1] & ~last_q[1];
    cs_fall   = ~stg_q[SYNC_STAGES-1][1] & last_q[1];
    din_s     = stg_q[SYNC_STAGES-1][0];
  end
endmodule

// File: rtl/dual_dac_shifter.sv
module dual_dac_shifter
  import dual_dac_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_rise,
  input  logic               sclk_fall,
  input  logic               cs_low,
  input  logic               cs_fall,
  input  logic               din_s,
  input  logic               edge_rise,
  output logic [FRAME_W-1:0] shreg_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               dout_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               echo_q, echo_d;
  logic               dout_q, dout_d;

  always_comb begin
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    echo_d = echo_q;
    dout_d = dout_q;
    if (cs_fall) cnt_d = '0;
    if (sclk_rise && cs_low) begin
      sr_d   = {sr_q[FRAME_W-2:0], din_s};
      echo_d = sr_q[FRAME_W-1];
      if (cnt_q != CNT_SAT) cnt_d = cnt_q + CNT_W'(1);
      if (edge_rise) dout_d = sr_q[FRAME_W-1];
    end
    if (sclk_fall && cs_low && !edge_rise) dout_d = echo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      echo_q <= 1'b0;
      dout_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      echo_q <= echo_d;
      dout_q <= dout_d;
    end
  end

  assign shreg_o = sr_q;
  assign cnt_o   = cnt_q;
  assign dout_o  = dout_q;
endmodule

// File: rtl/dual_dac_regbank.sv
module dual_dac_regbank
  import dual_dac_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        commit_i,
  input  frame_t                      frame_i,
  output logic [N_CH-1:0][DATA_W-1:0] code_o,
  output logic                        shdn_o,
  output logic                        gpo_o,
  output logic                        edge_rise_o
);
  logic [N_CH-1:0][DATA_W-1:0] stage_q, stage_d;
  logic [N_CH-1:0][DATA_W-1:0] live_q, live_d;
  logic shdn_q, shdn_d, wake_q, wake_d, gpo_q, gpo_d, erise_q, erise_d;

  always_comb begin
    stage_d = stage_q;
    live_d  = live_q;
    shdn_d  = shdn_q;
    wake_d  = wake_q;
    gpo_d   = gpo_q;
    erise_d = erise_q;
    if (commit_i) begin
      case (frame_i.cmd)
        CMD_STAGE: stage_d[frame_i.chan] = frame_i.data;
        CMD_STAGE_UPD: begin
          stage_d[frame_i.chan] = frame_i.data;
          live_d = stage_d;
        end
        CMD_UPDATE: live_d = stage_q;
        CMD_MODE: begin
          if (!frame_i.chan) begin
            shdn_d = frame_i.data[PWR_SHDN_BIT];
            gpo_d  = frame_i.data[PWR_GPO_BIT];
            if (frame_i.data[PWR_SHDN_BIT]) wake_d = frame_i.data[PWR_WAKE_BIT];
            if (shdn_q && !frame_i.data[PWR_SHDN_BIT] && wake_q) live_d = stage_q;
          end else begin
            erise_d = frame_i.data[EDGE_SEL_BIT];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      live_q  <= '0;
      shdn_q  <= 1'b0;
      wake_q  <= 1'b0;
      gpo_q   <= 1'b0;
      erise_q <= 1'b0;
    end else begin
      stage_q <= stage_d;
      live_q  <= live_d;
      shdn_q  <= shdn_d;
      wake_q  <= wake_d;
      gpo_q   <= gpo_d;
      erise_q <= erise_d;
    end
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_mask
    assign code_o[ch] = shdn_q ? '0 : live_q[ch];
  end

  assign shdn_o      = shdn_q;
  assign gpo_o       = gpo_q;
  assign edge_rise_o = erise_q;
endmodule

// File: rtl/dual_dac_cmd_if.sv
module dual_dac_cmd_if
  import dual_dac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  output logic              dout,
  output logic              gpo_o,
  output logic              shutdown_o,
  output logic [DATA_W-1:0] dac_a_o,
  output logic [DATA_W-1:0] dac_b_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic sclk_rise_w, sclk_fall_w, cs_low_w, cs_rise_w, cs_fall_w, din_w;
  logic [FRAME_W-1:0] shreg_w;
  logic [CNT_W-1:0]   bit_cnt_w;
  logic               edge_rise_w;
  logic               commit_w;
  logic [N_CH-1:0][DATA_W-1:0] codes_w;

  dual_dac_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n_s), .sclk(sclk), .cs_n(cs_n), .din(din),
    .sclk_rise(sclk_rise_w), .sclk_fall(sclk_fall_w), .cs_low(cs_low_w),
    .cs_rise(cs_rise_w), .cs_fall(cs_fall_w), .din_s(din_w)
  );

  dual_dac_shifter u_shifter (
    .clk(clk), .rst_n(rst_n_s), .sclk_rise(sclk_rise_w), .sclk_fall(sclk_fall_w),
    .cs_low(cs_low_w), .cs_fall(cs_fall_w), .din_s(din_w), .edge_rise(edge_rise_w),
    .shreg_o(shreg_w), .cnt_o(bit_cnt_w), .dout_o(dout)
  );

  assign commit_w = cs_rise_w && (bit_cnt_w == CNT_W'(FRAME_W));

  dual_dac_regbank u_regbank (
    .clk(clk), .rst_n(rst_n_s), .commit_i(commit_w), .frame_i(frame_t'(shreg_w)),
    .code_o(codes_w), .shdn_o(shutdown_o), .gpo_o(gpo_o), .edge_rise_o(edge_rise_w)
  );

  assign dac_a_o = codes_w[0];
  assign dac_b_o = codes_w[1];
endmodule

// File: rtl/dual_dac_cmd_if_chk.sv
module dual_dac_cmd_if_chk
  import dual_dac_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               dout,
  input logic               gpo_o,
  input logic               shutdown_o,
  input logic [DATA_W-1:0]  dac_a_o,
  input logic [DATA_W-1:0]  dac_b_o,
  input logic               commit_w,
  input logic               cs_rise_w,
  input logic               cs_low_w,
  input logic               sclk_rise_w,
  input logic               sclk_fall_w,
  input logic [CNT_W-1:0]   bit_cnt_w,
  input logic [FRAME_W-1:0] shreg_w
);
  // R6: visible state moves only in the cycle after a commit
  a_r6_hold_until_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_w |=> $stable({dac_a_o, dac_b_o, gpo_o, shutdown_o}));

  // R7: a chip-select rise with a wrong count changes nothing
  a_r7_short_frame_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise_w && bit_cnt_w != CNT_W'(FRAME_W)) |=> $stable({dac_a_o, dac_b_o, gpo_o, shutdown_o}));

  // R8: shift register holds while chip-select is high
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_low_w |=> $stable(shreg_w));

  // R10: outputs masked in shutdown
  a_r10_shdn_zero: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_o |-> (dac_a_o == '0 && dac_b_o == '0));

  // R12: echo output moves only after a detected serial clock edge
  a_r12_dout_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_rise_w || sclk_fall_w) |=> $stable(dout));
endmodule

bind dual_dac_cmd_if dual_dac_cmd_if_chk u_chk (.*);

// File: tb/dual_dac_cmd_if_tb.sv
module dual_dac_cmd_if_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 8;

  logic clk, rst_n, sclk, cs_n, din;
  logic dout, gpo_o, shutdown_o;
  logic [12:0] dac_a_o, dac_b_o;
  int checks, errors, cycles;

  dual_dac_cmd_if dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .dout(dout), .gpo_o(gpo_o), .shutdown_o(shutdown_o),
    .dac_a_o(dac_a_o), .dac_b_o(dac_b_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic ch, input logic [1:0] cmd, input logic [12:0] d);
    return {ch, cmd, d};
  endfunction

  // chk: 0 none, 1 check echo after rising edges, 2 after falling edges
  task automatic shift_bits(input logic [15:0] w, input int n, input int chk, input logic [15:0] exp);
    for (int i = 0; i < n; i++) begin
      din = w[15 - (i % 16)];
      wait_clks(HALF_BIT);
      sclk = 1'b1;
      wait_clks(HALF_BIT);
      if (chk == 1) check("R12 echo rising", 32'(dout), 32'(exp[15-i]));
      sclk = 1'b0;
      if (chk != 0) wait_clks(HALF_BIT);
      if (chk == 2) check("R12 echo falling", 32'(dout), 32'(exp[15-i]));
    end
  endtask

  task automatic xfer(input logic [15:0] w, input int n);
    cs_n = 1'b0;
    wait_clks(HALF_BIT);
    shift_bits(w, n, 0, 16'h0);
    wait_clks(HALF_BIT);
    cs_n = 1'b1;
    wait_clks(12);
  endtask

  task automatic t_reset;
    check("R1 dac_a", 32'(dac_a_o), 0);
    check("R1 dac_b", 32'(dac_b_o), 0);
    check("R1 gpo", 32'(gpo_o), 0);
    check("R1 shutdown", 32'(shutdown_o), 0);
    check("R1 dout", 32'(dout), 0);
  endtask

  task automatic t_stage_update;
    xfer(mk(0, 2'b00, 13'h1234), 16);
    check("R3 A unchanged after stage", 32'(dac_a_o), 0);
    xfer(mk(1, 2'b00, 13'h0ABC), 16);
    check("R3 B unchanged after stage", 32'(dac_b_o), 0);
    xfer(mk(0, 2'b10, 13'h1FFF), 16);
    check("R4 R2 A updated", 32'(dac_a_o), 32'h1234);
    check("R4 R2 B updated", 32'(dac_b_o), 32'h0ABC);
  endtask

  task automatic t_commit_on_cs;
    cs_n = 1'b0;
    wait_clks(HALF_BIT);
    shift_bits(mk(0, 2'b01, 13'h0555), 16, 0, 16'h0);
    wait_clks(20);
    check("R6 no change before cs rise", 32'(dac_a_o), 32'h1234);
    cs_n = 1'b1;
    wait_clks(12);
    check("R5 A staged and updated", 32'(dac_a_o), 32'h0555);
    check("R5 B updated from stage", 32'(dac_b_o), 32'h0ABC);
  endtask

  task automatic t_bad_count;
    xfer(mk(0, 2'b00, 13'h1FFF), 16);
    xfer(mk(0, 2'b10, 13'h0000), 15);
    check("R7 15-bit frame dropped", 32'(dac_a_o), 32'h0555);
    xfer(mk(0, 2'b10, 13'h0000), 17);
    check("R7 17-bit frame dropped", 32'(dac_a_o), 32'h0555);
    xfer(mk(0, 2'b10, 13'h0000), 16);
    check("R7 full frame applies", 32'(dac_a_o), 32'h1FFF);
  endtask

  task automatic t_bursts;
    logic [15:0] w;
    w = mk(1, 2'b01, 13'h0F0F);
    cs_n = 1'b0;
    wait_clks(HALF_BIT);
    shift_bits(w, 8, 0, 16'h0);
    wait_clks(40);
    shift_bits({w[7:0], 8'h00}, 8, 0, 16'h0);
    wait_clks(HALF_BIT);
    cs_n = 1'b1;
    wait_clks(12);
    check("R9 burst B", 32'(dac_b_o), 32'h0F0F);
    check("R9 burst A", 32'(dac_a_o), 32'h1FFF);
  endtask

  task automatic t_shutdown_wake;
    xfer(mk(0, 2'b11, 13'h1C00), 16);
    check("R10 shutdown on", 32'(shutdown_o), 1);
    check("R10 gpo high", 32'(gpo_o), 1);
    check("R10 A masked", 32'(dac_a_o), 0);
    check("R10 B masked", 32'(dac_b_o), 0);
    xfer(mk(0, 2'b00, 13'h0777), 16);
    xfer(mk(0, 2'b11, 13'h0800), 16);
    check("R10 shutdown off", 32'(shutdown_o), 0);
    check("R11 wake loads A", 32'(dac_a_o), 32'h0777);
    check("R11 wake B", 32'(dac_b_o), 32'h0F0F);
    check("R10 gpo kept", 32'(gpo_o), 1);
  endtask

  task automatic t_shutdown_retain;
    xfer(mk(0, 2'b11, 13'h1000), 16);
    check("R10 gpo low", 32'(gpo_o), 0);
    xfer(mk(0, 2'b00, 13'h0111), 16);
    xfer(mk(0, 2'b11, 13'h0000), 16);
    check("R11 retain A", 32'(dac_a_o), 32'h0777);
    check("R11 retain B", 32'(dac_b_o), 32'h0F0F);
  endtask

  task automatic t_echo;
    logic [15:0] g, m;
    g = mk(0, 2'b00, 13'h0A5A);
    xfer(g, 16);
    for (int k = 0; k < 5; k++) begin
      din = 1'b1;
      wait_clks(HALF_BIT); sclk = 1'b1;
      wait_clks(HALF_BIT); sclk = 1'b0;
    end
    wait_clks(12);
    check("R8 dout idle", 32'(dout), 32'(g[0]));
    cs_n = 1'b0;
    wait_clks(HALF_BIT);
    shift_bits(mk(1, 2'b00, 13'h0123), 16, 2, g);
    cs_n = 1'b1;
    wait_clks(12);
    m = mk(1, 2'b11, 13'h1000);
    xfer(m, 16);
    cs_n = 1'b0;
    wait_clks(HALF_BIT);
    shift_bits(mk(1, 2'b00, 13'h0000), 16, 1, m);
    cs_n = 1'b1;
    wait_clks(12);
    check("R12 outputs after echo frames A", 32'(dac_a_o), 32'h0777);
  endtask

  initial begin
    checks = 0; errors = 0; cycles = 0;
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; din = 1'b0;
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(5);
    t_reset;
    t_stage_update;
    t_commit_on_cs;
    t_bad_count;
    t_bursts;
    t_shutdown_wake;
    t_shutdown_retain;
    t_echo;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule